// File: doc/BRIEF.md
# Raster Timing Generator with Divided CPU Clock

This block sequences the horizontal and vertical scan of a 256x192 tile display engine from one master clock. A one-cycle pixel enable comes out every second master cycle, and a CPU clock comes out at one third of the master rate. Its phase is tied to the pixel grid, so every scan line lasts the same whole number of CPU cycles. Pixel and line counters drive flags for active picture, horizontal blanking and vertical blanking, a line-start strobe and a frame-start strobe.

A rate select chooses a short frame (60 Hz, 262 lines) or a long frame (50 Hz, 313 lines). The line length does not change between rates. At the end of the visible area the block latches a vertical-blank interrupt request. The request stays set until the CPU side strobes a status read. A memory-free flag tells the CPU-side logic when the display is not fetching, so that video memory can be accessed without throttling.

Top module: `raster_timing_gen`

## Requirements
- R1: While rst_ni is low, pix_cnt_o and line_cnt_o are 0, irq_o and pix_en_o are 0, and cpu_clk_o is 1. In the first cycle after release, pix_en_o is 1, cpu_clk_o is 0 and pix_cnt_o is still 0.
- R2: pix_en_o is high in exactly every second master cycle.
- R3: cpu_clk_o is high in exactly one of every three master cycles, repeating with period 3 from reset.
- R4: pix_cnt_o advances only on pix_en_o cycles and runs 0 to H_TOTAL-1 (341), so a line takes 2*H_TOTAL = 684 master cycles. line_start_o pulses on the pix_en_o cycle with pix_cnt_o = 0.
- R5: Every line holds exactly 228 cpu_clk_o high cycles, at both rates.
- R6: With the latched rate at 60 Hz (mode_50hz_i = 0), a frame has V_TOTAL_60 lines (262). At 50 Hz (mode_50hz_i = 1) it has V_TOTAL_50 lines (313). line_cnt_o runs from 0 to that count minus 1.
- R7: active_o is 1 exactly when pix_cnt_o < H_ACTIVE (256) and line_cnt_o < V_ACTIVE (192). hblank_o and vblank_o flag the pixel and line conditions outside those limits. A frame holds H_ACTIVE*V_ACTIVE active pixel-enable cycles.
- R8: irq_o rises in the first cycle of line V_ACTIVE, with pix_cnt_o = 0. It stays high until a cycle with stat_rd_i = 1, which clears it at the next edge. A set in the same cycle as a read wins.
- R9: mem_free_o is the inverse of active_o in every cycle.
- R10: mode_50hz_i is sampled only when the last line wraps to line 0. A change in mid-frame leaves that frame's length unchanged, and the first frame after reset is always a 60 Hz frame.
- R11: frame_start_o is a one-cycle pulse at the line_start_o of line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_50hz_i | input | 1 | Rate select: 1 = 50 Hz frame, 0 = 60 Hz frame |
| stat_rd_i | input | 1 | Status-read strobe, clears the interrupt request |
| pix_en_o | output | 1 | Pixel-rate enable, one master cycle in two |
| cpu_clk_o | output | 1 | CPU clock, master divided by 3 |
| pix_cnt_o | output | PIX_W (9) | Pixel position within the line |
| line_cnt_o | output | LINE_W (9) | Line position within the frame |
| active_o | output | 1 | Inside the visible picture |
| hblank_o | output | 1 | Pixel position past the visible width |
| vblank_o | output | 1 | Line position past the visible height |
| irq_o | output | 1 | Vertical-blank interrupt request |
| mem_free_o | output | 1 | Video memory free for unrestricted access |
| line_start_o | output | 1 | Strobe at the first pixel of each line |
| frame_start_o | output | 1 | Strobe at the first pixel of each frame |

## Verification
Both counters and the interrupt flop update on the edge that closes a pixel-enable cycle, so every flag is due in the first cycle after that edge. irq_o, for example, appears in the same cycle in which line_cnt_o first shows V_ACTIVE. The bench drives inputs and samples outputs on the falling edge, and it measures intervals between strobes instead of waiting fixed delays. A line is therefore judged over exactly 684 consecutive master cycles, and a frame over the strobes between two frame starts. The bench shrinks the vertical geometry to keep frames short and leaves the horizontal line at full length.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int unsigned H_TOTAL_DEF    = 342;
  localparam int unsigned H_ACTIVE_DEF   = 256;
  localparam int unsigned V_ACTIVE_DEF   = 192;
  localparam int unsigned V_TOTAL_60_DEF = 262;
  localparam int unsigned V_TOTAL_50_DEF = 313;
  localparam int unsigned PIX_DIV_DEF    = 2;
  localparam int unsigned CPU_DIV_DEF    = 3;

  typedef enum logic {
    RATE_60 = 1'b0,
    RATE_50 = 1'b1
  } frame_rate_e;
endpackage

// File: rtl/raster_clk_div.sv
module raster_clk_div #(
  parameter int unsigned DIV     = 2,
  parameter int unsigned TICK_AT = 0,
  localparam int unsigned CW     = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (cnt_q == CW'(DIV - 1)) cnt_q <= '0;
    else                            cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == CW'(TICK_AT));

  // R2 and R3: a tick never lasts two cycles and recurs every DIV cycles
  p_tick_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
  p_tick_period_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> ##DIV tick_o);
endmodule

// File: rtl/raster_hcount.sv
module raster_hcount #(
  parameter int unsigned H_TOTAL  = 342,
  parameter int unsigned H_ACTIVE = 256,
  parameter int unsigned PIX_W    = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pix_en_i,
  output logic [PIX_W-1:0] pix_cnt_o,
  output logic             line_end_o,
  output logic             hblank_o
);
  localparam logic [PIX_W-1:0] PIX_LAST = PIX_W'(H_TOTAL - 1);
  localparam logic [PIX_W-1:0] PIX_VIS  = PIX_W'(H_ACTIVE);

  logic [PIX_W-1:0] pix_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pix_q <= '0;
    else if (pix_en_i) begin
      if (pix_q == PIX_LAST) pix_q <= '0;
      else                   pix_q <= pix_q + 1'b1;
    end
  end

  assign line_end_o = pix_en_i && (pix_q == PIX_LAST);
  assign hblank_o   = (pix_q >= PIX_VIS);
  assign pix_cnt_o  = pix_q;

  p_pix_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_q <= PIX_LAST);
  p_pix_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_end_o |=> (pix_q == '0));
  p_pix_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_en_i |=> $stable(pix_q));
endmodule

// File: rtl/raster_vcount.sv
module raster_vcount
  import raster_pkg::*;
#(
  parameter int unsigned V_ACTIVE   = 192,
  parameter int unsigned V_TOTAL_60 = 262,
  parameter int unsigned V_TOTAL_50 = 313,
  parameter int unsigned LINE_W     = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_end_i,
  input  logic              rate_50_i,
  input  logic              stat_rd_i,
  output logic [LINE_W-1:0] line_cnt_o,
  output logic              irq_o,
  output logic              vblank_o
);
  localparam logic [LINE_W-1:0] LAST_60  = LINE_W'(V_TOTAL_60 - 1);
  localparam logic [LINE_W-1:0] LAST_50  = LINE_W'(V_TOTAL_50 - 1);
  localparam logic [LINE_W-1:0] VIS_LAST = LINE_W'(V_ACTIVE - 1);
  localparam logic [LINE_W-1:0] VIS_END  = LINE_W'(V_ACTIVE);

  logic [LINE_W-1:0] line_q;
  frame_rate_e       rate_q;
  logic              irq_q;
  logic [LINE_W-1:0] line_last;
  logic              frame_wrap;
  logic              irq_set;

  assign line_last  = (rate_q == RATE_50) ? LAST_50 : LAST_60;
  assign frame_wrap = line_end_i && (line_q == line_last);
  assign irq_set    = line_end_i && (line_q == VIS_LAST);

  // rate is latched only at the frame wrap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= '0;
      rate_q <= RATE_60;
    end else if (frame_wrap) begin
      line_q <= '0;
      rate_q <= rate_50_i ? RATE_50 : RATE_60;
    end else if (line_end_i) begin
      line_q <= line_q + 1'b1;
    end
  end

  // set wins over a coincident status read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_q <= 1'b0;
    else if (irq_set)   irq_q <= 1'b1;
    else if (stat_rd_i) irq_q <= 1'b0;
  end

  assign line_cnt_o = line_q;
  assign irq_o      = irq_q;
  assign vblank_o   = (line_q >= VIS_END);

  p_line_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_q <= LAST_50);
  p_line_60_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_q == RATE_60) |-> (line_q <= LAST_60));
  p_rate_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_q != '0) |-> $stable(rate_q));
  p_irq_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vblank_o) |-> irq_q);
  p_irq_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !stat_rd_i) |=> irq_q);
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter int unsigned H_TOTAL    = H_TOTAL_DEF,
  parameter int unsigned H_ACTIVE   = H_ACTIVE_DEF,
  parameter int unsigned V_ACTIVE   = V_ACTIVE_DEF,
  parameter int unsigned V_TOTAL_60 = V_TOTAL_60_DEF,
  parameter int unsigned V_TOTAL_50 = V_TOTAL_50_DEF,
  parameter int unsigned PIX_DIV    = PIX_DIV_DEF,
  parameter int unsigned CPU_DIV    = CPU_DIV_DEF,
  localparam int unsigned PIX_W     = $clog2(H_TOTAL),
  localparam int unsigned LINE_W    = $clog2(V_TOTAL_50)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_50hz_i,
  input  logic              stat_rd_i,
  output logic              pix_en_o,
  output logic              cpu_clk_o,
  output logic [PIX_W-1:0]  pix_cnt_o,
  output logic [LINE_W-1:0] line_cnt_o,
  output logic              active_o,
  output logic              hblank_o,
  output logic              vblank_o,
  output logic              irq_o,
  output logic              mem_free_o,
  output logic              line_start_o,
  output logic              frame_start_o
);
  logic line_end;

  raster_clk_div #(.DIV(PIX_DIV), .TICK_AT(PIX_DIV - 1)) u_pix_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (pix_en_o)
  );

  raster_clk_div #(.DIV(CPU_DIV), .TICK_AT(0)) u_cpu_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (cpu_clk_o)
  );

  raster_hcount #(
    .H_TOTAL  (H_TOTAL),
    .H_ACTIVE (H_ACTIVE),
    .PIX_W    (PIX_W)
  ) u_hcount (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pix_en_i   (pix_en_o),
    .pix_cnt_o  (pix_cnt_o),
    .line_end_o (line_end),
    .hblank_o   (hblank_o)
  );

  raster_vcount #(
    .V_ACTIVE   (V_ACTIVE),
    .V_TOTAL_60 (V_TOTAL_60),
    .V_TOTAL_50 (V_TOTAL_50),
    .LINE_W     (LINE_W)
  ) u_vcount (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_end_i (line_end),
    .rate_50_i  (mode_50hz_i),
    .stat_rd_i  (stat_rd_i),
    .line_cnt_o (line_cnt_o),
    .irq_o      (irq_o),
    .vblank_o   (vblank_o)
  );

  assign active_o      = !hblank_o && !vblank_o;
  assign mem_free_o    = !active_o;
  assign line_start_o  = pix_en_o && (pix_cnt_o == '0);
  assign frame_start_o = line_start_o && (line_cnt_o == '0);

  p_free_vblank_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_o |-> mem_free_o);
  p_free_hblank_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hblank_o |-> mem_free_o);
  p_frame_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> !frame_start_o);
  p_frame_line0_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> (line_cnt_o == '0) && (pix_cnt_o == '0));
endmodule

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int H_TOT  = 342;
  localparam int H_ACT  = 256;
  localparam int V_ACT  = 8;
  localparam int V60    = 12;
  localparam int V50    = 15;
  localparam int PW     = $clog2(H_TOT);
  localparam int LW     = $clog2(V50);
  localparam int WDOG   = 190000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mode_50hz = 1'b0;
  logic stat_rd = 1'b0;
  logic pix_en, cpu_clk, active, hblank, vblank, irq, mem_free, line_start, frame_start;
  logic [PW-1:0] pix_cnt;
  logic [LW-1:0] line_cnt;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  raster_timing_gen #(
    .H_TOTAL(H_TOT), .H_ACTIVE(H_ACT), .V_ACTIVE(V_ACT),
    .V_TOTAL_60(V60), .V_TOTAL_50(V50), .PIX_DIV(2), .CPU_DIV(3)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_50hz_i(mode_50hz), .stat_rd_i(stat_rd),
    .pix_en_o(pix_en), .cpu_clk_o(cpu_clk), .pix_cnt_o(pix_cnt), .line_cnt_o(line_cnt),
    .active_o(active), .hblank_o(hblank), .vblank_o(vblank), .irq_o(irq),
    .mem_free_o(mem_free), .line_start_o(line_start), .frame_start_o(frame_start)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_frame();
    do @(negedge clk); while (frame_start !== 1'b1);
  endtask

  // R1, R2, R3, R11
  task automatic t_reset();
    int en_err = 0;
    int cpu_err = 0;
    mode_50hz = 1'b1;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 pix_cnt in reset", pix_cnt, 0);
    chk("R1 line_cnt in reset", line_cnt, 0);
    chk("R1 irq in reset", irq, 0);
    chk("R1 pix_en in reset", pix_en, 0);
    chk("R1 cpu_clk in reset", cpu_clk, 1);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 pix_en after release", pix_en, 1);
    chk("R1 cpu_clk after release", cpu_clk, 0);
    chk("R1 pix_cnt after release", pix_cnt, 0);
    chk("R11 frame_start after release", frame_start, 1);
    for (int k = 1; k <= 24; k++) begin
      if (pix_en !== 1'((k % 2) == 1)) en_err++;
      if (cpu_clk !== 1'((k % 3) == 0)) cpu_err++;
      @(negedge clk);
    end
    chk("R2 pix_en pattern errors", en_err, 0);
    chk("R3 cpu_clk pattern errors", cpu_err, 0);
  endtask

  // R10: mode set during reset, first frame still 60 Hz
  task automatic t_first_frame();
    int lines = 1;
    while (frame_start !== 1'b1) begin
      if (line_start === 1'b1) lines++;
      @(negedge clk);
    end
    chk("R10 first frame is 60 Hz", lines, V60);
  endtask

  // R4, R5
  task automatic t_line(input string tag);
    int cyc = 0;
    int cpu = 0;
    int maxpix = 0;
    do @(negedge clk); while (line_start !== 1'b1);
    do begin
      @(negedge clk);
      cyc++;
      if (cpu_clk === 1'b1) cpu++;
      if (int'(pix_cnt) > maxpix) maxpix = int'(pix_cnt);
    end while (line_start !== 1'b1);
    chk({"R4 master cycles per line ", tag}, cyc, 2 * H_TOT);
    chk({"R4 last pixel index ", tag}, maxpix, H_TOT - 1);
    chk({"R5 cpu cycles per line ", tag}, cpu, 228);
  endtask

  // R6, R7, R8, R9, R11
  task automatic t_frame(input string tag, input int exp_lines);
    int lines = 1;
    int act = 1;
    int free_err = 0;
    int blank_err = 0;
    int irq_line = -1;
    int irq_pix = -1;
    int max_line = 0;
    int fs_cnt = 0;
    wait_frame();
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    chk({"R8 read clears irq ", tag}, irq, 0);
    forever begin
      @(negedge clk);
      if (frame_start === 1'b1) break;
      if (line_start === 1'b1) lines++;
      if (pix_en && active) act++;
      if (mem_free === active) free_err++;
      if (active !== 1'(int'(pix_cnt) < H_ACT && int'(line_cnt) < V_ACT)) blank_err++;
      if (vblank !== 1'(int'(line_cnt) >= V_ACT)) blank_err++;
      if (int'(line_cnt) > max_line) max_line = int'(line_cnt);
      if (irq === 1'b1 && irq_line < 0) begin
        irq_line = int'(line_cnt);
        irq_pix = int'(pix_cnt);
      end
      if (frame_start === 1'b1) fs_cnt++;
    end
    chk({"R6 lines per frame ", tag}, lines, exp_lines);
    chk({"R6 last line index ", tag}, max_line, exp_lines - 1);
    chk({"R7 active pixels per frame ", tag}, act, H_ACT * V_ACT);
    chk({"R7 flag mismatches ", tag}, blank_err, 0);
    chk({"R9 mem_free mismatches ", tag}, free_err, 0);
    chk({"R8 irq rise line ", tag}, irq_line, V_ACT);
    chk({"R8 irq rise pixel ", tag}, irq_pix, 0);
    chk({"R8 irq held to frame end ", tag}, irq, 1);
    chk({"R11 no stray frame_start ", tag}, fs_cnt, 0);
  endtask

  // R10: mid-frame change does not alter the running frame
  task automatic t_mode_switch();
    int lines = 1;
    wait_frame();
    forever begin
      @(negedge clk);
      if (frame_start === 1'b1) break;
      if (line_start === 1'b1) begin
        lines++;
        if (lines == 4) mode_50hz = 1'b0;
      end
    end
    chk("R10 frame length kept after mid-frame change", lines, V50);
  endtask

  initial begin
    t_reset();
    t_first_frame();
    t_line("50Hz");
    t_frame("50Hz", V50);
    t_mode_switch();
    t_frame("60Hz", V60);
    t_line("60Hz");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WDOG, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule